// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register and arithmetic half of a small processor in which every transfer between storage elements crosses one shared internal bus. It holds eight general registers, a program counter, an instruction register, a scratch register, a memory address register, a memory data register, an operand latch Y, an arithmetic/logic unit with no storage of its own, and a result latch Z. The block does not decide what happens in any cycle. An external control unit raises strobes that choose which single register drives the bus, which registers capture it, which ALU function runs and whether a memory transfer starts.

Because only one value can cross the bus per cycle, a two-operand operation is staged. First one operand is copied into Y. Next the other operand is placed on the bus while the ALU combines it with Y, or with the constant 4, and the result is captured in Z. Finally Z is moved to its destination. The memory data register connects to both sides. It can load from the bus or from the memory read data. Its contents are always presented on the memory write data lines. Reads and writes are held open until memory signals completion.

Top module: `single_bus_datapath`

## Requirements
- R1: During and after a synchronous reset every register (general, PC, IR, TEMP, MAR, MDR, Y, Z) is zero, `mem_rd_o` and `mem_wr_o` are low and the bus reads zero.
- R2: A register loads the bus value at a clock edge when its in-strobe is high and otherwise keeps its value. General register k uses `rf_in_i[k]` and `rf_out_i[k]`. The other registers use `ctl_i` bits: 0 PC out, 1 PC in, 2 IR out, 3 IR in, 4 TEMP out, 5 TEMP in, 6 MAR in, 7 MDR out, 8 MDR in from bus, 9 Y in, 10 Z out, 11 Z in.
- R3: With no out-strobe high, the bus reads zero. More than one out-strobe in a cycle is a protocol violation that an assertion flags.
- R4: The ALU A operand is Y when `ctl_i[12]` is low and the constant 4 when it is high. The B operand is the bus. The result changes only Z, and only on Z in. Z is visible on the bus only when Z out is high.
- R5: ALU codes on `alu_fn_i`: 4'h0 gives A+B+`carry_in_i`; 4'h1 gives B−A; 4'h2 gives A AND B; 4'h3 gives A OR B; 4'hF gives A XOR B; any other code passes B. Results wrap to the data width.
- R6: A register-to-register operation takes three cycles: source to Y, second source on the bus with the function and Z in, then Z to the destination. The result is on the bus during the third cycle.
- R7: MAR is always presented on `mem_addr_o`.
- R8: `ctl_i[13]` starts a read. `mem_rd_o` is high from the next cycle through the cycle in which `mem_done_i` is high. At the end of that cycle MDR takes `mem_rdata_i`.
- R9: `ctl_i[14]` starts a write. `mem_wr_o` is high from the next cycle through the cycle in which `mem_done_i` is high. MDR is always presented on `mem_wdata_o`.
- R10: If a read completes in the same cycle that MDR-in-from-bus is high, MDR takes the bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_i | input | 15 | Gating and memory strobes (bit map in R2, R4, R8, R9) |
| rf_out_i | input | NREG | Per-register bus drive strobes |
| rf_in_i | input | NREG | Per-register bus load strobes |
| alu_fn_i | input | 4 | ALU function code |
| carry_in_i | input | 1 | ALU carry-in for addition |
| mem_addr_o | output | DW | Memory address, always MAR |
| mem_wdata_o | output | DW | Memory write data, always MDR |
| mem_rdata_i | input | DW | Memory read data |
| mem_rd_o | output | 1 | Read request held until completion |
| mem_wr_o | output | 1 | Write request held until completion |
| mem_done_i | input | 1 | Memory completion signal |
| bus_o | output | DW | Current internal bus value |

## Verification
The assertions check on every cycle that at most one source drives the bus. They also check that each register, Z included, keeps its value without its load strobe, that a pending memory request stays up until completion and drops after it, and that MDR takes the right source at completion. Only the bench scenarios can show the arithmetic results for each function code and operand choice, the three-cycle staging of an operation, a stalled read waiting several cycles for completion, and the value MAR presents on the address lines.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    localparam int CTL_W = 15;

    // control strobe bit positions
    localparam int C_PC_OUT   = 0;
    localparam int C_PC_IN    = 1;
    localparam int C_IR_OUT   = 2;
    localparam int C_IR_IN    = 3;
    localparam int C_TMP_OUT  = 4;
    localparam int C_TMP_IN   = 5;
    localparam int C_MAR_IN   = 6;
    localparam int C_MDR_OUT  = 7;
    localparam int C_MDR_IN   = 8;
    localparam int C_Y_IN     = 9;
    localparam int C_Z_OUT    = 10;
    localparam int C_Z_IN     = 11;
    localparam int C_SEL_FOUR = 12;
    localparam int C_READ     = 13;
    localparam int C_WRITE    = 14;

    typedef enum logic [3:0] {
        FN_ADD = 4'h0,
        FN_SUB = 4'h1,
        FN_AND = 4'h2,
        FN_OR  = 4'h3,
        FN_XOR = 4'hF
    } alu_fn_e;

    function automatic logic strobe(input logic [CTL_W-1:0] c, input int pos);
        return c[pos];
    endfunction

endpackage

// File: rtl/sbd_gatereg.sv
module sbd_gatereg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (ld_i) q_o <= d_i;
    end

    // R2 / R4: without its load strobe a register keeps its value
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ld_i |=> $stable(q_o));

endmodule

// File: rtl/sbd_alu.sv
module sbd_alu
    import sbd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   fn_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o
);

    localparam logic [W-1:0] CIN_ZERO = '0;

    always_comb begin
        case (fn_i)
            FN_ADD:  res_o = a_i + b_i + {CIN_ZERO[W-1:1], cin_i};
            FN_SUB:  res_o = b_i - a_i;
            FN_AND:  res_o = a_i & b_i;
            FN_OR:   res_o = a_i | b_i;
            FN_XOR:  res_o = a_i ^ b_i;
            default: res_o = b_i;
        endcase
    end

endmodule

// File: rtl/sbd_memport.sv
module sbd_memport #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_req_i,
    input  logic         wr_req_i,
    input  logic         done_i,
    input  logic [W-1:0] rdata_i,
    input  logic         bus_ld_i,
    input  logic [W-1:0] bus_d_i,
    output logic [W-1:0] mdr_o,
    output logic         rd_o,
    output logic         wr_o
);

    logic rd_q, wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            mdr_o <= '0;
        end else begin
            rd_q <= rd_req_i | (rd_q & ~done_i);
            wr_q <= wr_req_i | (wr_q & ~done_i);
            if (bus_ld_i)           mdr_o <= bus_d_i;
            else if (rd_q && done_i) mdr_o <= rdata_i;
        end
    end

    assign rd_o = rd_q;
    assign wr_o = wr_q;

    // R8: a read stays open until completion
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        rd_q && !done_i |=> rd_q);
    // R8: completion captures read data
    assert_mdr_mem_R8: assert property (@(posedge clk) disable iff (rst)
        rd_q && done_i && !bus_ld_i |=> mdr_o == $past(rdata_i));
    // R10: bus load wins over memory completion
    assert_mdr_bus_R10: assert property (@(posedge clk) disable iff (rst)
        bus_ld_i |=> mdr_o == $past(bus_d_i));
    // R9: a write closes after completion
    assert_wr_drop_R9: assert property (@(posedge clk) disable iff (rst)
        wr_q && done_i && !wr_req_i |=> !wr_q);

endmodule

// File: rtl/single_bus_datapath.sv
module single_bus_datapath
    import sbd_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [NREG-1:0]   rf_out_i,
    input  logic [NREG-1:0]   rf_in_i,
    input  logic [3:0]        alu_fn_i,
    input  logic              carry_in_i,
    output logic [DW-1:0]     mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    input  logic              mem_done_i,
    output logic [DW-1:0]     bus_o
);

    localparam logic [DW-1:0] FOUR = DW'(4);
    localparam int NSRC = NREG + 5;

    logic [DW-1:0] bus;
    logic [DW-1:0] rf_q [NREG];
    logic [DW-1:0] pc_q, ir_q, tmp_q, mar_q, mdr_q, y_q, z_q;
    logic [DW-1:0] alu_a, alu_res;
    logic [NSRC-1:0] drivers;

    // general registers
    for (genvar k = 0; k < NREG; k++) begin : g_rf
        sbd_gatereg #(.W(DW)) u_r (
            .clk(clk), .rst(rst), .ld_i(rf_in_i[k]), .d_i(bus), .q_o(rf_q[k])
        );
    end

    sbd_gatereg #(.W(DW)) u_pc  (.clk(clk), .rst(rst), .ld_i(strobe(ctl_i, C_PC_IN)),  .d_i(bus),     .q_o(pc_q));
    sbd_gatereg #(.W(DW)) u_ir  (.clk(clk), .rst(rst), .ld_i(strobe(ctl_i, C_IR_IN)),  .d_i(bus),     .q_o(ir_q));
    sbd_gatereg #(.W(DW)) u_tmp (.clk(clk), .rst(rst), .ld_i(strobe(ctl_i, C_TMP_IN)), .d_i(bus),     .q_o(tmp_q));
    sbd_gatereg #(.W(DW)) u_mar (.clk(clk), .rst(rst), .ld_i(strobe(ctl_i, C_MAR_IN)), .d_i(bus),     .q_o(mar_q));
    sbd_gatereg #(.W(DW)) u_y   (.clk(clk), .rst(rst), .ld_i(strobe(ctl_i, C_Y_IN)),   .d_i(bus),     .q_o(y_q));
    sbd_gatereg #(.W(DW)) u_z   (.clk(clk), .rst(rst), .ld_i(strobe(ctl_i, C_Z_IN)),   .d_i(alu_res), .q_o(z_q));

    sbd_memport #(.W(DW)) u_mem (
        .clk(clk), .rst(rst),
        .rd_req_i(strobe(ctl_i, C_READ)),
        .wr_req_i(strobe(ctl_i, C_WRITE)),
        .done_i(mem_done_i),
        .rdata_i(mem_rdata_i),
        .bus_ld_i(strobe(ctl_i, C_MDR_IN)),
        .bus_d_i(bus),
        .mdr_o(mdr_q),
        .rd_o(mem_rd_o),
        .wr_o(mem_wr_o)
    );

    // operand multiplexer and ALU
    assign alu_a = strobe(ctl_i, C_SEL_FOUR) ? FOUR : y_q;

    sbd_alu #(.W(DW)) u_alu (
        .a_i(alu_a), .b_i(bus), .fn_i(alu_fn_i), .cin_i(carry_in_i), .res_o(alu_res)
    );

    // AND-OR bus: idle value is zero
    always_comb begin
        bus = '0;
        if (strobe(ctl_i, C_PC_OUT))  bus = bus | pc_q;
        if (strobe(ctl_i, C_IR_OUT))  bus = bus | ir_q;
        if (strobe(ctl_i, C_TMP_OUT)) bus = bus | tmp_q;
        if (strobe(ctl_i, C_MDR_OUT)) bus = bus | mdr_q;
        if (strobe(ctl_i, C_Z_OUT))   bus = bus | z_q;
        for (int k = 0; k < NREG; k++)
            if (rf_out_i[k]) bus = bus | rf_q[k];
    end

    assign drivers = {rf_out_i, ctl_i[C_PC_OUT], ctl_i[C_IR_OUT], ctl_i[C_TMP_OUT],
                      ctl_i[C_MDR_OUT], ctl_i[C_Z_OUT]};

    assign bus_o       = bus;
    assign mem_addr_o  = mar_q;
    assign mem_wdata_o = mdr_q;

    // R3: at most one source on the bus per cycle
    assert_single_driver_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drivers));

endmodule

// File: tb/single_bus_datapath_bench.sv
module single_bus_datapath_bench;
    import sbd_pkg::*;

    localparam int DW = 16;
    localparam int NREG = 8;
    localparam int NV = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CTL_W-1:0]  ctl = '0;
    logic [NREG-1:0]   rfo = '0, rfi = '0;
    logic [3:0]        fn = '0;
    logic              cin = 1'b0;
    logic [DW-1:0]     maddr, mwdata, busv;
    logic [DW-1:0]     rdata = '0;
    logic              mrd, mwr;
    logic              done = 1'b0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic fin = 1'b0;
    logic [DW-1:0] v;

    single_bus_datapath #(.DW(DW), .NREG(NREG)) u_single_bus_datapath (
        .clk(clk), .rst(rst), .ctl_i(ctl), .rf_out_i(rfo), .rf_in_i(rfi),
        .alu_fn_i(fn), .carry_in_i(cin), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
        .mem_rdata_i(rdata), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_done_i(done),
        .bus_o(busv)
    );

    always #4 clk = ~clk;   // 125 MHz

    // vector table: function, carry, four-select, Y operand, bus operand, result
    localparam logic [3:0]    V_FN  [NV] = '{4'h0, 4'h0, 4'h1, 4'h2, 4'h3, 4'hF, 4'h0, 4'h7, 4'h1};
    localparam logic          V_CIN [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic          V_S4  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [DW-1:0] V_A   [NV] = '{16'h1234, 16'hFFFF, 16'h0005, 16'hF0F0, 16'hF0F0,
                                             16'hAAAA, 16'h7777, 16'h1111, 16'h9999};
    localparam logic [DW-1:0] V_B   [NV] = '{16'h0F0F, 16'h0001, 16'h0003, 16'h3C3C, 16'h3C3C,
                                             16'h5555, 16'h0100, 16'hBEEF, 16'h0010};
    localparam logic [DW-1:0] V_EXP [NV] = '{16'h2143, 16'h0001, 16'hFFFE, 16'h3030, 16'hFCFC,
                                             16'hFFFF, 16'h0104, 16'hBEEF, 16'h000C};

    task automatic finish_run();
        if (!fin) begin
            fin = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 20000", cyc);
            finish_run();
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr();
        ctl = '0; rfo = '0; rfi = '0; fn = '0; cin = 1'b0; done = 1'b0; rdata = '0;
    endtask

    task automatic go();
        @(negedge clk);
        clr();
    endtask

    // bring a value into general register r through a memory read
    task automatic load_reg(input int r, input logic [DW-1:0] val);
        ctl[C_READ] = 1'b1; go();
        rdata = val; done = 1'b1; go();
        ctl[C_MDR_OUT] = 1'b1; rfi[r] = 1'b1; go();
    endtask

    task automatic read_reg(input int r, output logic [DW-1:0] val);
        rfo[r] = 1'b1; #1 val = busv; go();
    endtask

    initial begin
        clr();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 bus", busv, '0);
        check("R1 addr", maddr, '0);
        check("R1 wdata", mwdata, '0);
        check("R1 rd/wr", {14'd0, mrd, mwr}, '0);
        rst = 1'b0;
        go();

        // R5 / R6: vector table through the three-cycle staging
        for (int i = 0; i < NV; i++) begin
            load_reg(1, V_A[i]);
            load_reg(2, V_B[i]);
            rfo[1] = 1'b1; ctl[C_Y_IN] = 1'b1; go();
            rfo[2] = 1'b1; ctl[C_Z_IN] = 1'b1; ctl[C_SEL_FOUR] = V_S4[i];
            fn = V_FN[i]; cin = V_CIN[i]; go();
            ctl[C_Z_OUT] = 1'b1; rfi[3] = 1'b1;
            #1 check($sformatf("R6 R5 vec%0d Z on bus", i), busv, V_EXP[i]);
            go();
            read_reg(3, v);
            check($sformatf("R5 R4 vec%0d in R3", i), v, V_EXP[i]);
        end

        // R3: idle bus reads zero; R4: Z hidden without Z out
        #1 check("R3 idle bus", busv, '0);
        // R4: ALU runs with no Z in, Z must keep last result
        load_reg(2, 16'h0042);
        rfo[2] = 1'b1; fn = 4'h0; ctl[C_SEL_FOUR] = 1'b1; go();
        ctl[C_Z_OUT] = 1'b1; #1 check("R4 Z held", busv, V_EXP[NV-1]); go();

        // R2: register 4 holds while others load
        load_reg(4, 16'h5A5A);
        load_reg(5, 16'h1357);
        load_reg(6, 16'h2468);
        read_reg(4, v);
        check("R2 hold r4", v, 16'h5A5A);
        // R2: PC/TEMP/IR path
        rfo[5] = 1'b1; ctl[C_PC_IN] = 1'b1; go();
        ctl[C_PC_OUT] = 1'b1; ctl[C_TMP_IN] = 1'b1; go();
        ctl[C_TMP_OUT] = 1'b1; ctl[C_IR_IN] = 1'b1; go();
        ctl[C_IR_OUT] = 1'b1; #1 check("R2 pc-tmp-ir chain", busv, 16'h1357); go();

        // R7: MAR on address lines
        rfo[6] = 1'b1; ctl[C_MAR_IN] = 1'b1; go();
        check("R7 address", maddr, 16'h2468);

        // R8: stalled read
        ctl[C_READ] = 1'b1; #1 check("R8 rd low in strobe cycle", {15'd0, mrd}, 16'd0); go();
        for (int s = 0; s < 3; s++) begin
            #1 check($sformatf("R8 rd held stall%0d", s), {15'd0, mrd}, 16'd1); go();
        end
        rdata = 16'hC0DE; done = 1'b1; go();
        check("R8 rd dropped", {15'd0, mrd}, 16'd0);
        ctl[C_MDR_OUT] = 1'b1; #1 check("R8 MDR data", busv, 16'hC0DE); go();

        // R9: write with MDR from bus
        rfo[4] = 1'b1; ctl[C_MDR_IN] = 1'b1; go();
        check("R9 wdata", mwdata, 16'h5A5A);
        ctl[C_WRITE] = 1'b1; go();
        #1 check("R9 wr high", {15'd0, mwr}, 16'd1); go();
        done = 1'b1; #1 check("R9 wr high at done", {15'd0, mwr}, 16'd1); go();
        check("R9 wr dropped", {15'd0, mwr}, 16'd0);

        // R10: bus load wins over read completion
        ctl[C_READ] = 1'b1; go();
        rdata = 16'hDEAD; done = 1'b1; rfo[6] = 1'b1; ctl[C_MDR_IN] = 1'b1; go();
        ctl[C_MDR_OUT] = 1'b1; #1 check("R10 bus wins", busv, 16'h2468); go();

        finish_run();
    end

endmodule